// File: doc/BRIEF.md
# Framed Serial Register Access Port

This block is the host-facing serial port of a data converter. A host reaches the converter's internal registers through two active-low frame strobes: one for reads and one for writes. The port generates the serial clock itself from the system clock, and it drives or releases a single shared data line. Words are 24 bits long and move most significant bit first.

An address input picks the target. With the address low, reads and writes reach the control register. With it high, reads return the latest conversion result and writes load the calibration register. The conversion core hands each new result to the port with a one-cycle valid pulse. The port then drives an active-low ready flag until the host has shifted out the whole result word.

Either strobe may be raised in the middle of a word. The port keeps its place in the word and continues from the next unread or unloaded bit when the strobe falls again. This lets a host with narrow transfer units fetch a word in pieces.

Top module: `frame_reg_port`

## Requirements
- R1: While neither strobe is low, `sclk` is held high. While a strobe is low, `sclk` has a period of four `clk` cycles, low for two cycles and then high for two.
- R2: After `rx_frame_n` falls, the port drives bit 23 of the selected word on `sdata`. Each later bit appears after a falling `sclk` edge and stays stable through the following rising edge, so the host samples on rising edges, MSB first.
- R3: After `tx_frame_n` falls, the port captures `sdata` on each rising `sclk` edge, MSB first. When the 24th bit has been captured, the target register takes the assembled word.
- R4: The level of `reg_sel` when a word begins selects the target. 0 selects the control register for both reads and writes (`ctrl_word`). 1 selects the result holding register for reads and the calibration register for writes (`cal_word`). A write to one register leaves the other unchanged.
- R5: While `rx_frame_n` is high, the port does not drive `sdata`. If a read is paused mid-word, the next frame continues with the first bit not yet sampled, so the pieces together form the full word.
- R6: If a write is paused mid-word, the bit position is kept and the next frame continues with the next bit. The target register does not change until all 24 bits have been captured.
- R7: A `res_valid` pulse latches `res_word` into the holding register and drives `rdy_n` low. `rdy_n` stays low across any number of paused frames. It returns high only after all 24 bits of the result have been read with `reg_sel`=1. Reading the control register does not release it.
- R8: If a result arrives while a result read is in progress (paused or running), the word being read is not overwritten. When that read completes, the new result moves into the holding register and `rdy_n` stays low.
- R9: While `rst_n` is low at a clock edge, the port clears both bit counters, releases `sdata`, sets `rdy_n` high and `sclk` high, and clears the control and calibration registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_n | input | 1 | Read frame strobe, active low |
| tx_frame_n | input | 1 | Write frame strobe, active low |
| reg_sel | input | 1 | Register select: 0 control, 1 result/calibration |
| sclk | output | 1 | Serial clock generated by the port, idles high |
| sdata | inout | 1 | Shared serial data line |
| rdy_n | output | 1 | Result ready, active low |
| res_valid | input | 1 | One-cycle pulse marking a new result |
| res_word | input | 24 | New conversion result |
| ctrl_word | output | 24 | Control register contents |
| cal_word | output | 24 | Calibration register contents |

## Verification
The hardest case to reach is a new result that arrives while a result read is paused partway through, so that the holding register must stay frozen. The stimulus reads ten bits of a result and raises the read strobe. It then pulses a second result while the port is idle but in mid-word, and finishes the remaining fourteen bits. The bench expects the first value, with the ready flag still low. A second full read must then return the newer value and release the flag. Every table vector also breaks its writes and reads at a different bit position, including the first and the last, to exercise the kept counters.

// File: rtl/frp_pkg.sv
package frp_pkg;

  typedef enum logic [1:0] {
    LINK_IDLE = 2'd0,
    LINK_RD   = 2'd1,
    LINK_WR   = 2'd2
  } link_mode_e;

  // The read strobe has precedence when both strobes are low.
  function automatic link_mode_e decide_mode(input logic rx_n, input logic tx_n);
    if (!rx_n)      return LINK_RD;
    else if (!tx_n) return LINK_WR;
    else            return LINK_IDLE;
  endfunction

endpackage

// File: rtl/frp_sclk_gen.sv
module frp_sclk_gen
  import frp_pkg::*;
#(
  parameter int DIV_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_frame_n,
  input  logic       tx_frame_n,
  output link_mode_e mode_q,
  output logic       sclk,
  output logic       rise_ev,
  output logic       fall_ev,
  output logic       rd_start
);

  localparam int PH_W = DIV_LOG2;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'((1 << (PH_W - 1)) - 1);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  link_mode_e      mode_d;
  logic [PH_W-1:0] ph_q;
  logic            keep_run;

  assign mode_d   = decide_mode(rx_frame_n, tx_frame_n);
  assign keep_run = (mode_d == mode_q) && (mode_q != LINK_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= LINK_IDLE;
      ph_q   <= '0;
    end else begin
      mode_q <= mode_d;
      ph_q   <= keep_run ? ph_q + 1'b1 : '0;
    end
  end

  // Low for the first half of the phase count, high for the second half.
  assign sclk     = (mode_q == LINK_IDLE) ? 1'b1 : ph_q[PH_W-1];
  assign rise_ev  = keep_run && (ph_q == PH_RISE);
  assign fall_ev  = keep_run && (ph_q == PH_LAST);
  assign rd_start = (mode_d == LINK_RD) && (mode_q != LINK_RD);

endmodule

// File: rtl/frp_rd_path.sv
module frp_rd_path
  import frp_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  link_mode_e   mode_q,
  input  logic         rise_ev,
  input  logic         fall_ev,
  input  logic         rd_start,
  input  logic         rx_frame_n,
  input  logic         reg_sel,
  input  logic [W-1:0] ctrl_src,
  input  logic [W-1:0] hold_src,
  output logic         sd_oe,
  output logic         sd_bit,
  output logic         rd_done,
  output logic         rd_done_data,
  output logic         rd_busy_data
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] c);
    return (c == '0) ? LAST : c - 1'b1;
  endfunction

  logic [CW-1:0] rd_cnt;
  logic          rd_sel_q;
  logic          fresh;
  logic          src_sel;
  logic [W-1:0]  src;
  logic          rd_rise;

  assign fresh   = (rd_cnt == LAST);
  assign src_sel = (rd_start && fresh) ? reg_sel : rd_sel_q;
  assign src     = src_sel ? hold_src : ctrl_src;
  assign rd_rise = rise_ev && (mode_q == LINK_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt   <= LAST;
      rd_sel_q <= 1'b0;
      sd_bit   <= 1'b0;
    end else begin
      if (rd_start && fresh) rd_sel_q <= reg_sel;
      if (rd_start || (fall_ev && mode_q == LINK_RD)) sd_bit <= src[rd_cnt];
      if (rd_rise) rd_cnt <= step_down(rd_cnt);
    end
  end

  assign sd_oe        = (mode_q == LINK_RD);
  assign rd_done      = rd_rise && (rd_cnt == '0);
  assign rd_done_data = rd_done && rd_sel_q;
  assign rd_busy_data = (rd_sel_q && !fresh) || (!rx_frame_n && reg_sel && fresh);

endmodule

// File: rtl/frp_wr_path.sv
module frp_wr_path
  import frp_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  link_mode_e   mode_q,
  input  logic         rise_ev,
  input  logic         reg_sel,
  input  logic         sd_in,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] cal_q,
  output logic         wr_commit
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] c);
    return (c == '0) ? LAST : c - 1'b1;
  endfunction

  logic [CW-1:0] wr_cnt;
  logic [W-1:0]  sh_q;
  logic [W-1:0]  full_word;
  logic          wr_sel_q;
  logic          wr_rise;

  assign wr_rise   = rise_ev && (mode_q == LINK_WR);
  assign full_word = {sh_q[W-2:0], sd_in};
  assign wr_commit = wr_rise && (wr_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt   <= LAST;
      sh_q     <= '0;
      wr_sel_q <= 1'b0;
      ctrl_q   <= '0;
      cal_q    <= '0;
    end else if (wr_rise) begin
      if (wr_cnt == LAST) wr_sel_q <= reg_sel;
      sh_q   <= full_word;
      wr_cnt <= step_down(wr_cnt);
      if (wr_commit) begin
        if (wr_sel_q) cal_q  <= full_word;
        else          ctrl_q <= full_word;
      end
    end
  end

endmodule

// File: rtl/frp_rdy_hold.sv
module frp_rdy_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic [W-1:0] res_word,
  input  logic         rd_done_data,
  input  logic         rd_busy_data,
  output logic [W-1:0] hold_q,
  output logic         ready_q
);

  logic [W-1:0] pend_q;
  logic         pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      pend_q  <= '0;
      pend_v  <= 1'b0;
      ready_q <= 1'b0;
    end else if (rd_done_data) begin
      pend_v <= 1'b0;
      if (res_valid) begin
        hold_q  <= res_word;
        ready_q <= 1'b1;
      end else if (pend_v) begin
        hold_q  <= pend_q;
        ready_q <= 1'b1;
      end else begin
        ready_q <= 1'b0;
      end
    end else if (res_valid) begin
      if (rd_busy_data) begin
        pend_q <= res_word;
        pend_v <= 1'b1;
      end else begin
        hold_q  <= res_word;
        ready_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/frame_reg_port.sv
module frame_reg_port
  import frp_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int DIV_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_frame_n,
  input  logic              tx_frame_n,
  input  logic              reg_sel,
  output logic              sclk,
  inout  wire               sdata,
  output logic              rdy_n,
  input  logic              res_valid,
  input  logic [WORD_W-1:0] res_word,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] cal_word
);

  link_mode_e        mode_q;
  logic              rise_ev;
  logic              fall_ev;
  logic              rd_start;
  logic              sd_oe;
  logic              sd_bit;
  logic              rd_done;
  logic              rd_done_data;
  logic              rd_busy_data;
  logic              wr_commit;
  logic              ready_q;
  logic [WORD_W-1:0] hold_q;

  frp_sclk_gen #(.DIV_LOG2(DIV_LOG2)) u_clk (
    .clk(clk), .rst_n(rst_n), .rx_frame_n(rx_frame_n), .tx_frame_n(tx_frame_n),
    .mode_q(mode_q), .sclk(sclk), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .rd_start(rd_start)
  );

  frp_rd_path #(.W(WORD_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .rd_start(rd_start), .rx_frame_n(rx_frame_n),
    .reg_sel(reg_sel), .ctrl_src(ctrl_word), .hold_src(hold_q),
    .sd_oe(sd_oe), .sd_bit(sd_bit), .rd_done(rd_done),
    .rd_done_data(rd_done_data), .rd_busy_data(rd_busy_data)
  );

  frp_wr_path #(.W(WORD_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .rise_ev(rise_ev),
    .reg_sel(reg_sel), .sd_in(sdata), .ctrl_q(ctrl_word), .cal_q(cal_word),
    .wr_commit(wr_commit)
  );

  frp_rdy_hold #(.W(WORD_W)) u_rdy (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_word(res_word),
    .rd_done_data(rd_done_data), .rd_busy_data(rd_busy_data),
    .hold_q(hold_q), .ready_q(ready_q)
  );

  assign sdata = sd_oe ? sd_bit : 1'bz;
  assign rdy_n = ~ready_q;

endmodule

// File: rtl/frp_chk.sv
module frp_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_frame_n,
  input logic         tx_frame_n,
  input logic         sclk,
  input logic         rdy_n,
  input logic         sd_oe,
  input logic         rd_done,
  input logic         rd_done_data,
  input logic         wr_commit,
  input logic [W-1:0] ctrl_word,
  input logic [W-1:0] cal_word
);

  // R1
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_frame_n) && $past(tx_frame_n)) |-> sclk);

  // R5
  drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_frame_n) |-> !sd_oe);

  // R7
  rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> $past(rd_done_data));

  // R6
  ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(wr_commit));

  // R6
  cal_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cal_word) |-> $past(wr_commit));

  // R2
  done_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !rx_frame_n);

endmodule

bind frame_reg_port frp_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_frame_n(rx_frame_n), .tx_frame_n(tx_frame_n),
  .sclk(sclk), .rdy_n(rdy_n), .sd_oe(sd_oe), .rd_done(rd_done),
  .rd_done_data(rd_done_data), .wr_commit(wr_commit),
  .ctrl_word(ctrl_word), .cal_word(cal_word)
);

// File: tb/sim_frame_reg_port.sv
`timescale 1ns/1ps
module sim_frame_reg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_frame_n = 1'b1;
  logic        tx_frame_n = 1'b1;
  logic        reg_sel = 1'b0;
  logic        sclk;
  wire         sdata;
  logic        rdy_n;
  logic        res_valid = 1'b0;
  logic [23:0] res_word = '0;
  logic [23:0] ctrl_word;
  logic [23:0] cal_word;

  logic        host_oe = 1'b0;
  logic        host_bit = 1'b0;
  assign sdata = host_oe ? host_bit : 1'bz;

  int          checks = 0;
  int          failures = 0;
  int          wpos = 23;
  logic [23:0] acc = '0;
  logic [23:0] ctrl_exp = '0;

  always #10 clk = ~clk;

  frame_reg_port u0 (
    .clk(clk), .rst_n(rst_n), .rx_frame_n(rx_frame_n), .tx_frame_n(tx_frame_n),
    .reg_sel(reg_sel), .sclk(sclk), .sdata(sdata), .rdy_n(rdy_n),
    .res_valid(res_valid), .res_word(res_word), .ctrl_word(ctrl_word),
    .cal_word(cal_word)
  );

  // fields: control word [55:32], result word [31:8], pause position [7:0]
  localparam logic [55:0] VEC [5] = '{
    {24'hA5C30F, 24'h5A3CF0, 8'd1},
    {24'h000001, 24'h800000, 8'd23},
    {24'hFFFFFF, 24'h000000, 8'd12},
    {24'h13579B, 24'hFEDCBA, 8'd7},
    {24'h800000, 24'h7FFFFF, 8'd16}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_read(input logic sel, input int n);
    int   got = 0;
    logic prev = 1'b1;
    reg_sel = sel;
    rx_frame_n = 1'b0;
    while (got < n) begin
      @(negedge clk);
      if (!prev && sclk) begin
        acc = {acc[22:0], sdata};
        got++;
      end
      prev = sclk;
    end
    rx_frame_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_write(input logic sel, input logic [23:0] w, input int n);
    int   got = 0;
    logic prev = 1'b1;
    reg_sel = sel;
    host_bit = w[wpos];
    host_oe = 1'b1;
    tx_frame_n = 1'b0;
    while (got < n) begin
      @(negedge clk);
      if (!prev && sclk) begin
        got++;
        wpos--;
        if (wpos >= 0) host_bit = w[wpos];
      end
      prev = sclk;
    end
    tx_frame_n = 1'b1;
    @(negedge clk);
    host_oe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic push_result(input logic [23:0] w);
    res_word = w;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 rdy_n", {23'd0, rdy_n}, 24'd1);
    chk("R9 sclk", {23'd0, sclk}, 24'd1);
    chk("R9 ctrl", ctrl_word, 24'd0);
    chk("R9 cal", cal_word, 24'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle sclk", {23'd0, sclk}, 24'd1);

    // R1 serial clock period measured between two rising edges of a read
    begin
      int cyc = 0;
      int first = -1;
      int second = -1;
      logic prev = 1'b1;
      reg_sel = 1'b0;
      rx_frame_n = 1'b0;
      acc = '0;
      while (second < 0) begin
        @(negedge clk);
        cyc++;
        if (!prev && sclk) begin
          acc = {acc[22:0], sdata};
          if (first < 0) first = cyc; else second = cyc;
        end
        prev = sclk;
      end
      rx_frame_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 sclk period", 24'(second - first), 24'd4);
      chk("R1 sclk high while paused", {23'd0, sclk}, 24'd1);
      host_read(1'b0, 22);
      chk("R5 control read after pause", acc, 24'd0);
    end

    // table walk: paused writes, paused reads, results
    for (int i = 0; i < 5; i++) begin
      logic [23:0] cw;
      logic [23:0] rw;
      int p;
      cw = VEC[i][55:32];
      rw = VEC[i][31:8];
      p  = int'(VEC[i][7:0]);
      wpos = 23;
      host_write(1'b0, cw, p);
      chk("R6 partial write leaves control", ctrl_word, ctrl_exp);
      host_write(1'b0, cw, 24 - p);
      ctrl_exp = cw;
      chk("R3 control written", ctrl_word, cw);
      acc = '0;
      host_read(1'b0, p);
      host_read(1'b0, 24 - p);
      chk("R2 R5 control read back", acc, cw);
      push_result(rw);
      chk("R7 rdy after result", {23'd0, rdy_n}, 24'd0);
      acc = '0;
      host_read(1'b1, p);
      chk("R7 rdy held while paused", {23'd0, rdy_n}, 24'd0);
      host_read(1'b1, 24 - p);
      chk("R4 result read", acc, rw);
      chk("R7 rdy released", {23'd0, rdy_n}, 24'd1);
    end

    // R7 read of the last bit only releases the flag; control read keeps it
    push_result(24'h1B2D3F);
    acc = '0;
    host_read(1'b0, 24);
    chk("R7 control read keeps rdy", {23'd0, rdy_n}, 24'd0);
    chk("R4 control read", acc, ctrl_exp);
    acc = '0;
    host_read(1'b1, 23);
    chk("R7 rdy low before last bit", {23'd0, rdy_n}, 24'd0);
    host_read(1'b1, 1);
    chk("R7 result across pause", acc, 24'h1B2D3F);
    chk("R7 rdy high after last bit", {23'd0, rdy_n}, 24'd1);

    // R8 result arriving while a result read is paused
    push_result(24'h2468AC);
    acc = '0;
    host_read(1'b1, 10);
    push_result(24'hACE135);
    chk("R8 rdy still low", {23'd0, rdy_n}, 24'd0);
    host_read(1'b1, 14);
    chk("R8 old word kept", acc, 24'h2468AC);
    chk("R8 rdy low for new word", {23'd0, rdy_n}, 24'd0);
    acc = '0;
    host_read(1'b1, 24);
    chk("R8 new word", acc, 24'hACE135);
    chk("R8 rdy released", {23'd0, rdy_n}, 24'd1);

    // R4 calibration write leaves control alone
    wpos = 23;
    host_write(1'b1, 24'h3C5A96, 24);
    chk("R4 cal written", cal_word, 24'h3C5A96);
    chk("R4 control untouched", ctrl_word, ctrl_exp);

    // R9 reset in the middle of a write clears the bit counter
    wpos = 23;
    host_write(1'b0, 24'hFACE12, 7);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 control cleared", ctrl_word, 24'd0);
    chk("R9 cal cleared", cal_word, 24'd0);
    wpos = 23;
    host_write(1'b0, 24'h0F1E2D, 24);
    chk("R9 full write after reset", ctrl_word, 24'h0F1E2D);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule